// File: doc/BRIEF.md
# Segment Partition Controller

This block watches one repeater port and cuts that port's segment off the network when the segment misbehaves. Misbehaviour means a run of packets that each carry a collision, or a transmission that the segment never echoes back. It lets the segment rejoin once a long, collision-free packet has passed through it. The port logic feeds it three activity levels: segment receive, repeater transmit and collision. It also gets a bit-time strobe. Its outputs are an isolation flag and a two-bit code that records why the port was last isolated.

Five options are latched from a configuration word during the power-up mode-load strobe. One turns isolation off completely. One picks a limit of 31 or 63 consecutive colliding packets. One makes late collisions count the same way early ones do. One admits only repeater-sourced packets as reconnection packets. One adds a loopback check on the port's own transmissions. A one-cycle software reset pulse, raised when software writes one to the port's partition status bit, clears the machine and reconnects the port at once.

Top module: `seg_part_ctrl`

## Requirements
- R1: After reset, and in the cycle after a mode-load strobe, `partitioned` is 0 and `part_reason` is 2'b00 (none). The mode-load strobe latches `cfg_word` as bit0 no-isolate, bit1 limit-63, bit2 count-late, bit3 tx-only reconnect and bit4 loopback check.
- R2: A packet is one unbroken interval in which any of `rx_act`, `tx_act` or `col` is high. An early collision is a collision seen while fewer than 512 bit ticks have passed since the packet began. Each packet with an early collision adds one to a consecutive count. With bit1 clear, the packet that brings the count to 31 isolates the port when it ends, with reason 2'b01.
- R3: With bit1 set, the isolating count is 63 instead of 31.
- R4: A connected packet with no collision resets the consecutive count to zero.
- R5: With bit2 clear, a packet whose only collision is late (512 or more bit ticks in) leaves the count unchanged.
- R6: With bit2 set, a late-only collision counts at the packet's end. If that count isolates the port, the reason is 2'b10.
- R7: While isolated, a packet lasting at least 450 bit ticks with no collision reconnects the port when it ends. Shorter packets and colliding packets do not.
- R8: With bit3 set, only a packet that began with `tx_act` high can reconnect the port.
- R9: With bit4 set, a repeater-sourced packet isolates the port with reason 2'b11 if it reaches bit tick 96 and neither `rx_act` nor `col` was high on any tick from 61 to 96.
- R10: A port isolated by the loopback check reconnects under the same rule as R7.
- R11: With bit0 set, the port never becomes isolated.
- R12: A `sw_reset` pulse gives `partitioned` 0 and `part_reason` 2'b00 in the next cycle, and it clears the consecutive count.
- R13: `part_reason` keeps the cause of the latest isolation after reconnection, until a reset, `sw_reset` or mode-load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One pulse per network bit time |
| rx_act | input | 1 | Segment receive activity |
| tx_act | input | 1 | Repeater transmitting onto the segment |
| col | input | 1 | Collision present on the segment |
| cfg_load | input | 1 | Mode-load strobe; latches cfg_word and clears state |
| cfg_word | input | 5 | Option bits, encoding in R1 |
| sw_reset | input | 1 | Software partition reset pulse |
| partitioned | output | 1 | Segment is isolated |
| part_reason | output | 2 | Cause of latest isolation: 00 none, 01 count, 10 late, 11 loopback |

## Verification
On every cycle, the assertions check that isolation only begins at a packet's end or on a loopback failure. They also check that it only ends at a packet's end or on a reset-type strobe. Beyond that, they check that the count never passes the selected limit, that an isolated port always shows a non-zero reason, and that the no-isolate option holds. Some behaviours depend on whole packet histories: the exact packet that crosses the limit, whether a late collision leaves the count alone, and which packets qualify to reconnect. The bench's scenarios and its reference model alone can show these.

// File: rtl/seg_part_pkg.sv
package seg_part_pkg;

  typedef enum logic [1:0] {
    RSN_NONE = 2'b00,
    RSN_CCNT = 2'b01,
    RSN_LATE = 2'b10,
    RSN_LOOP = 2'b11
  } rsn_e;

  typedef enum logic {
    ST_LINKED   = 1'b0,
    ST_ISOLATED = 1'b1
  } pst_e;

  // bit order fixed by the external cfg_word encoding
  typedef struct packed {
    logic lbk;
    logic txonly;
    logic owce;
    logic lim63;
    logic nopart;
  } cfg_t;

  // summary of a packet, valid in the cycle after its last active cycle
  typedef struct packed {
    logic valid;
    logic early;
    logic late;
    logic tx_src;
    logic long_ok;
  } pend_t;

endpackage

// File: rtl/spc_rst_sync.sv
module spc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/spc_pkt_track.sv
module spc_pkt_track
  import seg_part_pkg::*;
#(
  parameter int unsigned LATE_WIN  = 512,
  parameter int unsigned RECON_MIN = 450,
  parameter int unsigned LB_LO     = 61,
  parameter int unsigned LB_HI     = 96
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  bit_tick,
  input  logic  rx_act,
  input  logic  tx_act,
  input  logic  col,
  input  logic  lbk_en,
  output pend_t pend,
  output logic  pkt_end,
  output logic  lb_fail
);
  localparam int unsigned MAX_A = (LATE_WIN > RECON_MIN) ? LATE_WIN : RECON_MIN;
  localparam int unsigned MAX_B = (MAX_A > LB_HI) ? MAX_A : LB_HI;
  localparam int unsigned CMAX  = MAX_B + 1;
  localparam int unsigned CW    = $clog2(CMAX + 1);
  localparam logic [CW-1:0] CMAX_C = CW'(CMAX);
  localparam logic [CW-1:0] LW_C   = CW'(LATE_WIN);
  localparam logic [CW-1:0] RC_C   = CW'(RECON_MIN);
  localparam logic [CW-1:0] LO_C   = CW'(LB_LO);
  localparam logic [CW-1:0] HI_C   = CW'(LB_HI);

  logic          act, act_q, start;
  logic [CW-1:0] bcnt_q, bcnt_d, cnt_now;
  logic          early_q, early_d, late_q, late_d;
  logic          txs_q, txs_d, echo_q, echo_d;
  logic          e_base, l_base, s_base, txs_now, in_win, echo_now;
  logic          en;

  always_comb begin
    act      = rx_act | tx_act | col;
    start    = act & ~act_q;
    pkt_end  = act_q & ~act;
    cnt_now  = start ? '0 : bcnt_q;
    e_base   = start ? 1'b0 : early_q;
    l_base   = start ? 1'b0 : late_q;
    s_base   = start ? 1'b0 : echo_q;
    txs_now  = start ? tx_act : txs_q;
    in_win   = (cnt_now >= LO_C) && (cnt_now <= HI_C);
    echo_now = rx_act | col;

    bcnt_d  = bcnt_q;
    early_d = early_q;
    late_d  = late_q;
    txs_d   = txs_q;
    echo_d  = echo_q;
    if (act) begin
      if (start)
        bcnt_d = bit_tick ? CW'(1) : '0;
      else if (bit_tick && (bcnt_q != CMAX_C))
        bcnt_d = bcnt_q + CW'(1);
      early_d = e_base | (col && (cnt_now < LW_C));
      late_d  = l_base | (col && (cnt_now >= LW_C));
      echo_d  = s_base | (bit_tick && in_win && echo_now);
      txs_d   = txs_now;
    end

    lb_fail = lbk_en & act & txs_now & tx_act & bit_tick &
              (cnt_now == HI_C) & ~s_base & ~echo_now;

    pend.valid   = pkt_end;
    pend.early   = early_q;
    pend.late    = late_q;
    pend.tx_src  = txs_q;
    pend.long_ok = (bcnt_q >= RC_C);

    en = clr | act | act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      bcnt_q  <= '0;
      early_q <= 1'b0;
      late_q  <= 1'b0;
      txs_q   <= 1'b0;
      echo_q  <= 1'b0;
    end else if (en) begin
      if (clr) begin
        act_q   <= 1'b0;
        bcnt_q  <= '0;
        early_q <= 1'b0;
        late_q  <= 1'b0;
        txs_q   <= 1'b0;
        echo_q  <= 1'b0;
      end else begin
        act_q   <= act;
        bcnt_q  <= bcnt_d;
        early_q <= early_d;
        late_q  <= late_d;
        txs_q   <= txs_d;
        echo_q  <= echo_d;
      end
    end
  end
endmodule

// File: rtl/spc_coll_cnt.sv
module spc_coll_cnt #(
  parameter int unsigned CCW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           inc,
  input  logic           zero,
  input  logic [CCW-1:0] lim,
  output logic [CCW-1:0] cnt,
  output logic           will_hit
);
  logic [CCW-1:0] cnt_d;
  logic           en;

  always_comb begin
    will_hit = (cnt >= (lim - CCW'(1)));
    cnt_d    = cnt;
    if (clr || zero)               cnt_d = '0;
    else if (inc && (cnt != lim))  cnt_d = cnt + CCW'(1);
    en = clr | zero | inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (en) cnt <= cnt_d;
  end
endmodule

// File: rtl/spc_part_fsm.sv
module spc_part_fsm
  import seg_part_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  cfg_t       cfg,
  input  pend_t      pend,
  input  logic       lb_fail,
  input  logic       will_hit,
  output logic       cnt_inc,
  output logic       cnt_zero,
  output logic       reconnect,
  output logic       isolated,
  output logic [1:0] rsn
);
  pst_e st_q, st_d;
  rsn_e rsn_q, rsn_d;
  logic counted, clean, upd;

  always_comb begin
    counted   = pend.early | (pend.late & cfg.owce);
    clean     = ~pend.early & ~pend.late;
    cnt_inc   = (st_q == ST_LINKED) & pend.valid & counted;
    cnt_zero  = (st_q == ST_LINKED) & pend.valid & clean;
    reconnect = (st_q == ST_ISOLATED) & pend.valid & clean & pend.long_ok &
                (~cfg.txonly | pend.tx_src);

    st_d  = st_q;
    rsn_d = rsn_q;
    if (clr) begin
      st_d  = ST_LINKED;
      rsn_d = RSN_NONE;
    end else if (st_q == ST_LINKED) begin
      if (!cfg.nopart) begin
        if (lb_fail) begin
          st_d  = ST_ISOLATED;
          rsn_d = RSN_LOOP;
        end else if (cnt_inc && will_hit) begin
          st_d  = ST_ISOLATED;
          rsn_d = pend.early ? RSN_CCNT : RSN_LATE;
        end
      end
    end else begin
      if (reconnect) st_d = ST_LINKED;
    end
    upd = clr | (st_d != st_q) | (rsn_d != rsn_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_LINKED;
      rsn_q <= RSN_NONE;
    end else if (upd) begin
      st_q  <= st_d;
      rsn_q <= rsn_d;
    end
  end

  assign isolated = (st_q == ST_ISOLATED);
  assign rsn      = rsn_q;
endmodule

// File: rtl/seg_part_ctrl.sv
module seg_part_ctrl
  import seg_part_pkg::*;
#(
  parameter int unsigned LATE_WIN  = 512,
  parameter int unsigned RECON_MIN = 450,
  parameter int unsigned LB_LO     = 61,
  parameter int unsigned LB_HI     = 96,
  parameter int unsigned LIM_LO    = 31,
  parameter int unsigned LIM_HI    = 63
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       rx_act,
  input  logic       tx_act,
  input  logic       col,
  input  logic       cfg_load,
  input  logic [4:0] cfg_word,
  input  logic       sw_reset,
  output logic       partitioned,
  output logic [1:0] part_reason
);
  localparam int unsigned CCW = $clog2(LIM_HI + 1);

  logic           rst_s, clr;
  cfg_t           cfg_q;
  pend_t          pend;
  logic           pkt_end, lb_fail;
  logic           cnt_inc, cnt_zero, reconnect, will_hit;
  logic [CCW-1:0] coll_cnt, cnt_lim;

  spc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_s));

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)        cfg_q <= '0;
    else if (cfg_load) cfg_q <= cfg_t'(cfg_word);
  end

  assign clr     = sw_reset | cfg_load;
  assign cnt_lim = cfg_q.lim63 ? CCW'(LIM_HI) : CCW'(LIM_LO);

  spc_pkt_track #(
    .LATE_WIN(LATE_WIN), .RECON_MIN(RECON_MIN), .LB_LO(LB_LO), .LB_HI(LB_HI)
  ) u_trk (
    .clk(clk), .rst_n(rst_s), .clr(clr), .bit_tick(bit_tick),
    .rx_act(rx_act), .tx_act(tx_act), .col(col), .lbk_en(cfg_q.lbk),
    .pend(pend), .pkt_end(pkt_end), .lb_fail(lb_fail)
  );

  spc_coll_cnt #(.CCW(CCW)) u_cnt (
    .clk(clk), .rst_n(rst_s), .clr(clr | reconnect), .inc(cnt_inc),
    .zero(cnt_zero), .lim(cnt_lim), .cnt(coll_cnt), .will_hit(will_hit)
  );

  spc_part_fsm u_fsm (
    .clk(clk), .rst_n(rst_s), .clr(clr), .cfg(cfg_q), .pend(pend),
    .lb_fail(lb_fail), .will_hit(will_hit), .cnt_inc(cnt_inc),
    .cnt_zero(cnt_zero), .reconnect(reconnect), .isolated(partitioned),
    .rsn(part_reason)
  );
endmodule

// File: rtl/seg_part_chk.sv
module seg_part_chk #(
  parameter int unsigned CCW = 6
) (
  input logic           clk,
  input logic           rst_sn,
  input logic           sw_reset,
  input logic           cfg_load,
  input logic           partitioned,
  input logic [1:0]     part_reason,
  input logic           pkt_end,
  input logic           lb_fail,
  input logic           nopart_q,
  input logic [CCW-1:0] coll_cnt,
  input logic [CCW-1:0] cnt_lim
);
  p_swrst_clears_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    sw_reset |=> (!partitioned && part_reason == 2'b00));

  p_part_cause_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(partitioned) |-> $past(pkt_end || lb_fail));

  p_reconnect_edge_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(partitioned) |-> $past(pkt_end || sw_reset || cfg_load));

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    coll_cnt <= cnt_lim);

  p_reason_set_r13: assert property (@(posedge clk) disable iff (!rst_sn)
    partitioned |-> part_reason != 2'b00);

  p_loop_iso_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (lb_fail && !partitioned && !nopart_q && !sw_reset && !cfg_load)
      |=> (partitioned && part_reason == 2'b11));

  p_no_iso_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    (nopart_q && !partitioned && !cfg_load) |=> !partitioned);
endmodule

bind seg_part_ctrl seg_part_chk #(.CCW(CCW)) u_chk (
  .clk(clk), .rst_sn(rst_s), .sw_reset(sw_reset), .cfg_load(cfg_load),
  .partitioned(partitioned), .part_reason(part_reason), .pkt_end(pkt_end),
  .lb_fail(lb_fail), .nopart_q(cfg_q.nopart), .coll_cnt(coll_cnt),
  .cnt_lim(cnt_lim)
);

// File: tb/seg_part_ctrl_bench.sv
`timescale 1ns/1ps
module seg_part_ctrl_bench;
  localparam int LW = 512;
  localparam int RC = 450;
  localparam int LO = 61;
  localparam int HI = 96;

  logic       clk = 1'b0;
  logic       rst_n, bit_tick, rx_act, tx_act, col, cfg_load, sw_reset;
  logic [4:0] cfg_word;
  logic       partitioned;
  logic [1:0] part_reason;

  int total = 0;
  int bad   = 0;

  // reference model state
  int       m_cnt;
  bit       m_part;
  bit [1:0] m_rsn;
  bit c_nopart, c_lim63, c_owce, c_txonly, c_lbk;

  always #2.5 clk = ~clk;

  seg_part_ctrl u_seg_part_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_act(rx_act),
    .tx_act(tx_act), .col(col), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .sw_reset(sw_reset), .partitioned(partitioned), .part_reason(part_reason)
  );

  task automatic check(string rq);
    total++;
    if (partitioned !== m_part || part_reason !== m_rsn) begin
      bad++;
      $display("FAIL %s: got part=%0b rsn=%0b, expected part=%0b rsn=%0b",
               rq, partitioned, part_reason, m_part, m_rsn);
    end
  endtask

  function automatic int lim_of();
    return c_lim63 ? 63 : 31;
  endfunction

  // reference for one packet: col from cs to the end, rx echo on [es,ee)
  task automatic model_pkt(int L, bit is_tx, int cs, int es, int ee);
    bit has_col, early, late, seen, lbf;
    has_col = (cs >= 0) && (cs < L);
    early   = has_col && (cs < LW);
    late    = has_col && (L > LW);
    seen    = 1'b0;
    for (int k = LO; k <= HI; k++)
      if ((is_tx && k >= es && k < ee) || (!is_tx) || (has_col && k >= cs)) seen = 1'b1;
    lbf = c_lbk && is_tx && !m_part && !c_nopart && (L > HI) && !seen;
    if (lbf) begin
      m_part = 1'b1;
      m_rsn  = 2'b11;
    end
    if (!m_part) begin
      if (early || (late && c_owce)) begin
        if (m_cnt >= lim_of() - 1 && !c_nopart) begin
          m_part = 1'b1;
          m_rsn  = early ? 2'b01 : 2'b10;
        end
        if (m_cnt < lim_of()) m_cnt++;
      end else if (!early && !late) begin
        m_cnt = 0;
      end
    end else if (!early && !late && L >= RC && (!c_txonly || is_tx)) begin
      m_part = 1'b0;
      m_cnt  = 0;
    end
  endtask

  task automatic send_pkt(int L, bit is_tx, int cs, int es, int ee);
    for (int k = 0; k < L; k++) begin
      @(negedge clk);
      tx_act = is_tx;
      rx_act = is_tx ? (k >= es && k < ee) : 1'b1;
      col    = (cs >= 0 && k >= cs);
    end
    @(negedge clk);
    tx_act = 1'b0; rx_act = 1'b0; col = 1'b0;
    repeat (3) @(negedge clk);
    model_pkt(L, is_tx, cs, es, ee);
  endtask

  task automatic col_pkts(int n);
    for (int i = 0; i < n; i++) send_pkt(20, 1'b0, 5, 0, 0);
  endtask

  task automatic load_cfg(bit np, bit l63, bit ow, bit tx, bit lb);
    @(negedge clk);
    cfg_word = {lb, tx, ow, l63, np};
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    c_nopart = np; c_lim63 = l63; c_owce = ow; c_txonly = tx; c_lbk = lb;
    m_cnt = 0; m_part = 1'b0; m_rsn = 2'b00;
  endtask

  task automatic pulse_swrst();
    @(negedge clk);
    sw_reset = 1'b1;
    @(negedge clk);
    sw_reset = 1'b0;
    m_cnt = 0; m_part = 1'b0; m_rsn = 2'b00;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; bit_tick = 1'b1; rx_act = 1'b0; tx_act = 1'b0; col = 1'b0;
    cfg_load = 1'b0; sw_reset = 1'b0; cfg_word = 5'd0;
    c_nopart = 0; c_lim63 = 0; c_owce = 0; c_txonly = 0; c_lbk = 0;
    m_cnt = 0; m_part = 0; m_rsn = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset state");

    // R2: 31 early-collision packets isolate with reason 01
    load_cfg(0, 0, 0, 0, 0);
    check("R1 after mode load");
    col_pkts(30);
    check("R2 30 collisions still linked");
    col_pkts(1);
    check("R2 31st collision isolates");

    // R7/R13: reconnection rules
    send_pkt(100, 1'b0, -1, 0, 0);
    check("R7 short packet no reconnect");
    send_pkt(500, 1'b0, 400, 0, 0);
    check("R7 colliding long packet no reconnect");
    send_pkt(460, 1'b0, -1, 0, 0);
    check("R7 long clean packet reconnects");
    check("R13 reason kept after reconnect");

    // R4: clean packet resets the run
    col_pkts(20);
    send_pkt(30, 1'b0, -1, 0, 0);
    col_pkts(30);
    check("R4 count cleared by clean packet");
    col_pkts(1);
    check("R4 isolation after fresh run");

    // R12
    pulse_swrst();
    check("R12 software reset reconnects");
    col_pkts(30);
    check("R12 count cleared by software reset");

    // R3
    load_cfg(0, 1, 0, 0, 0);
    col_pkts(62);
    check("R3 62 collisions linked at limit 63");
    col_pkts(1);
    check("R3 63rd collision isolates");

    // R5: late collision without count-late option
    load_cfg(0, 0, 0, 0, 0);
    col_pkts(30);
    send_pkt(600, 1'b0, 550, 0, 0);
    check("R5 late collision not counted");
    col_pkts(1);
    check("R5 late collision did not clear count");

    // R6
    load_cfg(0, 0, 1, 0, 0);
    col_pkts(30);
    send_pkt(600, 1'b0, 550, 0, 0);
    check("R6 late collision isolates with reason 10");

    // R8
    load_cfg(0, 0, 0, 1, 0);
    col_pkts(31);
    send_pkt(460, 1'b0, -1, 0, 0);
    check("R8 segment-sourced packet ignored");
    send_pkt(460, 1'b1, -1, 0, 460);
    check("R8 repeater-sourced packet reconnects");

    // R9/R10
    load_cfg(0, 0, 0, 0, 1);
    send_pkt(120, 1'b1, -1, 0, 0);
    check("R9 missing echo isolates with reason 11");
    send_pkt(460, 1'b1, -1, 0, 460);
    check("R10 loopback isolation reconnects normally");
    send_pkt(120, 1'b1, -1, 70, 80);
    check("R9 echo in window keeps link");
    send_pkt(90, 1'b1, -1, 0, 0);
    check("R9 packet shorter than window keeps link");
    send_pkt(120, 1'b1, -1, 10, 50);
    check("R9 echo outside window isolates");

    // R11
    load_cfg(1, 0, 0, 0, 1);
    col_pkts(40);
    send_pkt(120, 1'b1, -1, 0, 0);
    check("R11 no-isolate option holds");

    // constrained random mix
    for (int r = 0; r < 12; r++) begin
      load_cfg(($urandom % 5) == 0, ($urandom % 4) == 0, $urandom % 2,
               $urandom % 2, $urandom % 2);
      for (int p = 0; p < 22; p++) begin
        int L, cs, es, ee;
        bit tx;
        L  = (($urandom % 10) < 3) ? 440 + ($urandom % 180) : 2 + ($urandom % 140);
        tx = $urandom % 2;
        cs = (($urandom % 10) < 6) ? ($urandom % L) : -1;
        es = $urandom % 120;
        ee = es + ($urandom % 60);
        send_pkt(L, tx, cs, es, ee);
        check("R2 R4 R6 R7 R9 random packet");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule